// File: doc/BRIEF.md
# Dual-Direction Latch/Register Transfer Path

This block moves an 18-bit lane (16 data bits and 2 byte-parity bits) in each of two directions, A-to-B and B-to-A. Each direction has its own stage that behaves, at run time, either as a transparent latch or as an edge-triggered register. The choice is made by the level of that direction's transparency input. While transparency is asserted the driven output follows the live input. While it is deasserted, the stage either holds its stored word or loads a new one on a rising edge of that direction's transfer clock.

The whole block runs on one system clock. Each transfer-clock input is treated as an asynchronous signal. It passes through a synchroniser, and an edge is declared when the synchronised level is high and its value one system cycle earlier was low. The output of each direction is a mux between the live input and the stored word. A registered drive-enable, taken from an active-low output-enable input, stands in for three-state pins, and the data outputs read as zero whenever drive is off. Parity is only carried, never computed or checked.

Top module: `dual_xfer_path`

## Requirements
- R1: While `rst` is high, both drive flags are 0, both data and parity outputs are 0, stored words clear to 0 and synchroniser state clears to low.
- R2: While a direction's drive flag is 0, its data and parity outputs are all 0, whatever its other inputs are.
- R3: A direction's drive flag equals the inverse of its active-low output-enable input as sampled at the previous system clock edge.
- R4: While transparency is high and drive is on, the outputs equal the live inputs in the same cycle.
- R5: While transparency is high, the stored word is reloaded at every system edge. When transparency falls, the outputs show the lane value present at the last edge at which transparency was high.
- R6: With transparency low, a transfer-clock rise is captured as follows. Let the input be sampled low at system edge n-1 and high at edge n. The lane present at edge n+2 is then stored and appears at the outputs after that edge. This timing uses the default 2-stage synchroniser.
- R7: With transparency low and no detected transfer-clock rise, the outputs keep the stored word, whether the transfer clock is steady high or steady low.
- R8: A transfer-clock rise while transparency is high has no effect beyond the normal transparent reload.
- R9: Parity bits travel through the same storage and mux as the data bits. In the internal 18-bit lane, bits 17:16 are parity and bits 15:0 are data.
- R10: The two directions share no control. Any pattern on one direction's inputs leaves the other direction's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ab_transp | input | 1 | A-to-B transparency select (high = follow input) |
| ab_xfer_clk | input | 1 | A-to-B transfer clock, asynchronous, rising edge loads |
| ab_out_en_n | input | 1 | A-to-B output enable, active low |
| ab_data_in | input | 16 | A-to-B data input |
| ab_par_in | input | 2 | A-to-B byte parity input |
| ab_data_out | output | 16 | A-to-B data output |
| ab_par_out | output | 2 | A-to-B parity output |
| ab_drive | output | 1 | A-to-B drive enable |
| ba_transp | input | 1 | B-to-A transparency select |
| ba_xfer_clk | input | 1 | B-to-A transfer clock |
| ba_out_en_n | input | 1 | B-to-A output enable, active low |
| ba_data_in | input | 16 | B-to-A data input |
| ba_par_in | input | 2 | B-to-A byte parity input |
| ba_data_out | output | 16 | B-to-A data output |
| ba_par_out | output | 2 | B-to-A parity output |
| ba_drive | output | 1 | B-to-A drive enable |

## Verification
The bench targets the frozen value at the falling edge of transparency. A design that samples one cycle late, or that stops reloading during transparency, shows the wrong word right after the fall. It holds the transfer clock steady high with transparency low and changes the input every cycle. A level-sensitive capture instead of an edge-sensitive one would let the output track that input. It toggles the transfer clock during transparency and then drops transparency with the clock high, which catches an edge detector that reports a rise it has already seen. It also exercises the two directions with opposite patterns and parity-only changes, so a shared control or a dropped parity bit shows up as a miscompare.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  // Action the storage element takes at a system clock edge.
  typedef enum logic [1:0] {
    XM_FOLLOW  = 2'd0,
    XM_HOLD    = 2'd1,
    XM_CAPTURE = 2'd2
  } xfer_mode_e;

  // Transparency wins over a transfer-clock rise.
  function automatic xfer_mode_e pick_mode(input logic transp, input logic rise);
    if (transp)    return XM_FOLLOW;
    else if (rise) return XM_CAPTURE;
    else           return XM_HOLD;
  endfunction

endpackage

// File: rtl/xfer_edge_det.sv
module xfer_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[LAST];
  end

  assign rise_o = chain[LAST] & ~prev;

  // R6: a detected rise lasts exactly one system cycle
  p_rise_single_r6: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/xfer_store.sv
module xfer_store
  import xfer_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         transp,
  input  logic         rise,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  xfer_mode_e mode;

  assign mode = pick_mode(transp, rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (mode)
        XM_FOLLOW, XM_CAPTURE: q <= din;
        XM_HOLD:               q <= q;
        default:               q <= q;
      endcase
    end
  end

  // R5: transparency reloads the word every edge
  p_follow_load_r5: assert property (@(posedge clk) disable iff (rst)
    transp |=> (q == $past(din)));

  // R6: a rise with transparency low loads the lane
  p_capture_r6: assert property (@(posedge clk) disable iff (rst)
    (!transp && rise) |=> (q == $past(din)));

  // R7: no transparency and no rise keeps the word
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!transp && !rise) |=> $stable(q));

endmodule

// File: rtl/xfer_drive.sv
module xfer_drive #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         out_en_n,
  input  logic         transp,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout,
  output logic         drive
);
  logic [W-1:0] picked;

  always_ff @(posedge clk) begin
    if (rst) drive <= 1'b0;
    else     drive <= ~out_en_n;
  end

  assign picked = transp ? live : stored;
  assign dout   = drive ? picked : '0;

  // R3: disabling the output drops drive one edge later
  p_drive_off_r3: assert property (@(posedge clk) disable iff (rst)
    out_en_n |=> !drive);

  // R3: enabling the output raises drive one edge later
  p_drive_on_r3: assert property (@(posedge clk) disable iff (rst)
    !out_en_n |=> drive);

endmodule

// File: rtl/xfer_dir.sv
module xfer_dir #(
  parameter int W      = 18,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         transp,
  input  logic         xfer_clk,
  input  logic         out_en_n,
  input  logic [W-1:0] lane_in,
  output logic [W-1:0] lane_out,
  output logic         drive
);
  logic         rise;
  logic [W-1:0] stored;

  xfer_edge_det #(.STAGES(STAGES)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .async_in(xfer_clk),
    .rise_o  (rise)
  );

  xfer_store #(.W(W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .transp(transp),
    .rise  (rise),
    .din   (lane_in),
    .q     (stored)
  );

  xfer_drive #(.W(W)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .out_en_n(out_en_n),
    .transp  (transp),
    .live    (lane_in),
    .stored  (stored),
    .dout    (lane_out),
    .drive   (drive)
  );

  // R7: the driven held output does not move without a load
  p_quiet_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!transp && $past(!transp) && !$past(rise) && drive && $past(drive))
      |-> $stable(lane_out));

  // R2: no drive means a quiet lane
  p_off_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !drive |-> (lane_out == '0));

endmodule

// File: rtl/dual_xfer_path.sv
module dual_xfer_path #(
  parameter int DATA_W      = 16,
  parameter int PAR_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ab_transp,
  input  logic              ab_xfer_clk,
  input  logic              ab_out_en_n,
  input  logic [DATA_W-1:0] ab_data_in,
  input  logic [PAR_W-1:0]  ab_par_in,
  output logic [DATA_W-1:0] ab_data_out,
  output logic [PAR_W-1:0]  ab_par_out,
  output logic              ab_drive,
  input  logic              ba_transp,
  input  logic              ba_xfer_clk,
  input  logic              ba_out_en_n,
  input  logic [DATA_W-1:0] ba_data_in,
  input  logic [PAR_W-1:0]  ba_par_in,
  output logic [DATA_W-1:0] ba_data_out,
  output logic [PAR_W-1:0]  ba_par_out,
  output logic              ba_drive
);
  localparam int LANE_W = DATA_W + PAR_W;
  localparam int NDIR   = 2;

  // R9: parity sits in the top bits of the lane, data below
  logic [LANE_W-1:0] lane_in  [NDIR];
  logic [LANE_W-1:0] lane_out [NDIR];
  logic [NDIR-1:0]   transp, xclk, oen_n, drv;

  assign lane_in[0] = {ab_par_in, ab_data_in};
  assign lane_in[1] = {ba_par_in, ba_data_in};
  assign transp     = {ba_transp, ab_transp};
  assign xclk       = {ba_xfer_clk, ab_xfer_clk};
  assign oen_n      = {ba_out_en_n, ab_out_en_n};

  generate
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      xfer_dir #(.W(LANE_W), .STAGES(SYNC_STAGES)) u_dir (
        .clk     (clk),
        .rst     (rst),
        .transp  (transp[d]),
        .xfer_clk(xclk[d]),
        .out_en_n(oen_n[d]),
        .lane_in (lane_in[d]),
        .lane_out(lane_out[d]),
        .drive   (drv[d])
      );
    end
  endgenerate

  assign {ab_par_out, ab_data_out} = lane_out[0];
  assign {ba_par_out, ba_data_out} = lane_out[1];
  assign ab_drive = drv[0];
  assign ba_drive = drv[1];

  // R1: reset leaves both directions undriven at the next edge
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!ab_drive && !ba_drive));

endmodule

// File: tb/dual_xfer_path_tb.sv
`timescale 1ns/1ps
module dual_xfer_path_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic        le   [2];
  logic        xc   [2];
  logic        oen  [2];
  logic [15:0] din  [2];
  logic [1:0]  pin  [2];
  logic [15:0] dout [2];
  logic [1:0]  pout [2];
  logic        drv  [2];

  dual_xfer_path u_dut (
    .clk        (clk),
    .rst        (rst),
    .ab_transp  (le[0]),
    .ab_xfer_clk(xc[0]),
    .ab_out_en_n(oen[0]),
    .ab_data_in (din[0]),
    .ab_par_in  (pin[0]),
    .ab_data_out(dout[0]),
    .ab_par_out (pout[0]),
    .ab_drive   (drv[0]),
    .ba_transp  (le[1]),
    .ba_xfer_clk(xc[1]),
    .ba_out_en_n(oen[1]),
    .ba_data_in (din[1]),
    .ba_par_in  (pin[1]),
    .ba_data_out(dout[1]),
    .ba_par_out (pout[1]),
    .ba_drive   (drv[1])
  );

  // Behavioural reference: stored word, drive flag and the history of
  // sampled transfer-clock levels (bit0 = one edge ago, bit2 = three).
  logic [17:0] m_store [2];
  logic        m_drv   [2];
  logic [2:0]  m_hist  [2];

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  task automatic model_edge();
    for (int d = 0; d < 2; d++) begin
      if (rst) begin
        m_store[d] = '0;
        m_drv[d]   = 1'b0;
        m_hist[d]  = '0;
      end else begin
        logic rise;
        rise = m_hist[d][1] & ~m_hist[d][2];
        if (le[d] || rise) m_store[d] = {pin[d], din[d]};
        m_drv[d]  = ~oen[d];
        m_hist[d] = {m_hist[d][1:0], xc[d]};
      end
    end
  endtask

  task automatic check(input string tag);
    for (int d = 0; d < 2; d++) begin
      logic [17:0] exp_lane;
      logic [17:0] got_lane;
      exp_lane = m_drv[d] ? (le[d] ? {pin[d], din[d]} : m_store[d]) : 18'h0;
      got_lane = {pout[d], dout[d]};
      vectors++;
      if (got_lane !== exp_lane || drv[d] !== m_drv[d]) begin
        fails++;
        $display("FAIL %s dir%0d t=%0t: lane got %h exp %h, drive got %b exp %b",
                 tag, d, $time, got_lane, exp_lane, drv[d], m_drv[d]);
      end
    end
  endtask

  // Inputs are set just after a falling edge; outputs compared 1 ns later.
  task automatic step(input string tag);
    #1 check(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic set_dir(input int d, input logic l, input logic x,
                         input logic o, input logic [15:0] v, input logic [1:0] p);
    le[d] = l; xc[d] = x; oen[d] = o; din[d] = v; pin[d] = p;
  endtask

  initial begin
    rst = 1'b1;
    for (int d = 0; d < 2; d++) begin
      set_dir(d, 1'b0, 1'b0, 1'b1, 16'h0, 2'b0);
      m_store[d] = '0; m_drv[d] = 1'b0; m_hist[d] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R1: reset state, even with enabled outputs and moving inputs
    set_dir(0, 1'b1, 1'b1, 1'b0, 16'hBEEF, 2'b11);
    set_dir(1, 1'b0, 1'b1, 1'b0, 16'h1234, 2'b01);
    step("R1"); step("R1");
    rst = 1'b0;
    set_dir(0, 1'b0, 1'b0, 1'b0, 16'h0, 2'b0);
    set_dir(1, 1'b0, 1'b0, 1'b0, 16'h0, 2'b0);
    step("R1"); step("R3");

    // R4: transparent mode, live input seen in the same cycle
    for (int i = 0; i < 8; i++) begin
      set_dir(0, 1'b1, 1'b0, 1'b0, 16'($urandom), 2'($urandom));
      set_dir(1, 1'b1, 1'b0, 1'b0, 16'($urandom), 2'($urandom));
      step("R4");
    end

    // R5: freeze on the falling edge of transparency
    set_dir(0, 1'b1, 1'b0, 1'b0, 16'hA5A5, 2'b10);
    step("R5");
    set_dir(0, 1'b0, 1'b0, 1'b0, 16'h5A5A, 2'b01);
    for (int i = 0; i < 4; i++) begin
      step("R5");
      din[0] = 16'($urandom);
    end

    // R6: transfer-clock rise captures with synchroniser latency
    set_dir(0, 1'b0, 1'b0, 1'b0, 16'h1111, 2'b00);
    step("R6");
    xc[0] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      din[0] = 16'h2000 + 16'(i);
      pin[0] = 2'(i);
      step("R6");
    end

    // R7: steady-high then steady-low transfer clock holds the word
    for (int i = 0; i < 6; i++) begin
      din[0] = 16'($urandom);
      step("R7");
    end
    xc[0] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      din[0] = 16'($urandom);
      step("R7");
    end

    // R8: rises during transparency, then drop transparency with clock high
    le[0] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      xc[0]  = ~xc[0];
      din[0] = 16'($urandom);
      step("R8");
    end
    xc[0] = 1'b1;
    step("R8");
    le[0] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      din[0] = 16'($urandom);
      step("R8");
    end

    // R9: only parity changes across clocked loads
    for (int i = 0; i < 4; i++) begin
      set_dir(0, 1'b0, 1'b0, 1'b0, 16'hC3C3, 2'(i));
      repeat (2) step("R9");
      xc[0] = 1'b1;
      repeat (4) step("R9");
    end

    // R2: disabled outputs stay quiet under any activity
    oen[0] = 1'b1; oen[1] = 1'b1;
    for (int i = 0; i < 10; i++) begin
      for (int d = 0; d < 2; d++)
        set_dir(d, 1'($urandom), 1'($urandom), 1'b1, 16'($urandom), 2'($urandom));
      step("R2");
    end
    oen[0] = 1'b0; oen[1] = 1'b0;
    step("R3"); step("R3");

    // R10: one direction churns while the other holds
    set_dir(1, 1'b0, 1'b0, 1'b0, 16'h7777, 2'b11);
    for (int i = 0; i < 20; i++) begin
      set_dir(0, 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
              16'($urandom), 2'($urandom));
      din[1] = 16'($urandom);
      step("R10");
    end

    // R1: reset in mid-run
    rst = 1'b1;
    step("R1");
    rst = 1'b0;
    step("R1");

    // Mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      for (int d = 0; d < 2; d++) begin
        if ($urandom % 8 == 0)  le[d]  = ~le[d];
        if ($urandom % 3 == 0)  xc[d]  = ~xc[d];
        if ($urandom % 16 == 0) oen[d] = ~oen[d];
        din[d] = 16'($urandom);
        pin[d] = 2'($urandom);
      end
      step("R4/R6/R7 mix");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule